// File: doc/BRIEF.md
# NAPOT Physical Memory Protection Unit

This block checks each load, store and instruction fetch against a set of protection regions. Each region has an 8-bit configuration entry and an address register. Both are written and read through a simple CSR port. Only two region modes exist: disabled, and naturally aligned power-of-two (NAPOT). A NAPOT region is encoded by the run of trailing ones in its address register. The smallest region covers `GRAIN_BYTES` bytes, which defaults to 8.

When an access hits several active regions, the lowest-numbered one decides the outcome. Lock bits do two things. They freeze a region against further CSR writes, and they make its permissions apply to machine mode too. The fault output is combinational: the CPU presents an access and samples the fault flag in the same cycle.

The number of regions is set by `REGION_COUNT`, from 1 to 64. CSR slots for regions that are not implemented read as zero and ignore writes. They never signal an illegal access.

Top module: `pmp_unit`

## Requirements
- R1: After reset, every configuration CSR (0x3a0 to 0x3af) reads zero.
- R2: Configuration word 0x3a0+w holds the entries of regions 4w to 4w+3, with region 4w+j in bits 8j+7:8j. Each entry has this layout: bit 7 = lock, bits 4:3 = mode, bit 2 = execute, bit 1 = write, bit 0 = read. Bits 6:5 always read zero.
- R3: A write of mode 01 or 10 stores mode 00 (off). Only 00 and 11 (NAPOT) are ever held.
- R4: Address CSR 0x3b0+i holds byte-address bits 31:2 of region i in bits 29:0. Bits 31:30 read zero.
- R5: For a region index at or above `REGION_COUNT`, the configuration and address CSR slots read zero and ignore writes.
- R6: While a region's lock bit is set, writes to its configuration entry and its address register are ignored. The lock bit is cleared only by reset.
- R7: A NAPOT region whose address register ends in k ones (k ≥ 0) covers 2^(k+3) bytes, aligned to its own size. Its coverage is never smaller than `GRAIN_BYTES`.
- R8: When several active regions match, the lowest-numbered one alone decides the result.
- R9: The access kind is encoded in `accKind` as 0 = load (checked against read), 1 = store (checked against write), 2 = fetch (checked against execute), 3 = checked as a load. `fault` is zero whenever `accValid` is low.
- R10: The outcome for an access that is matched by no region, or by an unlocked region, depends on privilege:
  - A user-mode access that matches no region faults.
  - A machine-mode access that matches no region, or that matches an unlocked region, is allowed.
  - A machine-mode access that matches a locked region is checked against that region's permissions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csrWe | input | 1 | CSR write strobe |
| csrAddr | input | 12 | CSR address for both read and write |
| csrWdata | input | 32 | CSR write data |
| csrRdata | output | 32 | CSR read data (combinational) |
| accValid | input | 1 | Access present |
| accAddr | input | 32 | Access byte address |
| accKind | input | 2 | 0 load, 1 store, 2 fetch |
| accMachine | input | 1 | 1 = machine mode, 0 = user mode |
| fault | output | 1 | Access denied (combinational) |

## Verification
The assertions run on every cycle and cover these properties:
- reserved bits and the illegal mode codes never appear in a configuration read;
- the upper address bits read zero;
- slots for unimplemented regions read zero;
- lock bits never fall outside reset;
- machine mode never faults while no region is locked;
- no fault is raised without an access.

The bench scenarios cover the rest. These are the reset contents, the byte layout, ignored writes to locked regions, NAPOT region sizes at their edges, and lowest-index priority over overlapping regions. Random CSR traffic and random accesses are compared against a reference model.

// File: rtl/pmp_pkg.sv
package pmp_pkg;
  localparam int CSR_W = 32;
  localparam logic [1:0] MODE_OFF   = 2'b00;
  localparam logic [1:0] MODE_NAPOT = 2'b11;

  typedef struct packed {
    logic       lock;
    logic [1:0] rsvd;
    logic [1:0] mode;
    logic       x;
    logic       w;
    logic       r;
  } pmpCfgT;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_OTHER = 2'd3
  } accKindT;

  typedef struct packed {
    logic       cfgWe;
    logic       addrWe;
    logic       cfgRd;
    logic       addrRd;
    logic [3:0] cfgWord;
    logic [5:0] addrIdx;
  } csrStrobeT;

  // Clear the reserved bits and fold unsupported modes to off.
  function automatic pmpCfgT sanitizeCfg(input logic [7:0] raw);
    pmpCfgT c;
    c      = pmpCfgT'(raw);
    c.rsvd = 2'b00;
    if (c.mode != MODE_NAPOT) c.mode = MODE_OFF;
    return c;
  endfunction
endpackage

// File: rtl/pmp_ctrl.sv
module pmp_ctrl
  import pmp_pkg::*;
#(
  parameter int REGION_COUNT = 8
) (
  input  logic        csrWe,
  input  logic [11:0] csrAddr,
  output csrStrobeT   stb
);
  localparam logic [11:0] CFG_BASE  = 12'h3a0;
  localparam logic [11:0] CFG_LAST  = 12'h3af;
  localparam logic [11:0] ADDR_BASE = 12'h3b0;
  localparam logic [11:0] ADDR_LAST = 12'h3ef;
  localparam logic [6:0]  COUNT7    = 7'(REGION_COUNT);

  logic [11:0] addrOff;
  logic        inCfg;
  logic        inAddr;
  logic        cfgImpl;
  logic        addrImpl;

  always_comb begin
    addrOff  = csrAddr - ADDR_BASE;
    inCfg    = (csrAddr >= CFG_BASE) && (csrAddr <= CFG_LAST);
    inAddr   = (csrAddr >= ADDR_BASE) && (csrAddr <= ADDR_LAST);
    cfgImpl  = {1'b0, csrAddr[3:0], 2'b00} < COUNT7;
    addrImpl = {1'b0, addrOff[5:0]} < COUNT7;

    stb.cfgWord = csrAddr[3:0];
    stb.addrIdx = addrOff[5:0];
    stb.cfgRd   = inCfg;
    stb.addrRd  = inAddr && addrImpl;
    stb.cfgWe   = csrWe && inCfg && cfgImpl;
    stb.addrWe  = csrWe && inAddr && addrImpl;
  end
endmodule

// File: rtl/pmp_datapath.sv
module pmp_datapath
  import pmp_pkg::*;
#(
  parameter int REGION_COUNT = 8,
  parameter int GRAIN_BYTES  = 8,
  parameter int ADDR_W       = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  csrStrobeT               stb,
  input  logic [CSR_W-1:0]        csrWdata,
  output logic [CSR_W-1:0]        csrRdata,
  input  logic                    accValid,
  input  logic [ADDR_W-1:0]       accAddr,
  input  logic [1:0]              accKind,
  input  logic                    accMachine,
  output logic                    fault,
  output logic [REGION_COUNT-1:0] lockVec
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] GRAIN_MASK = WORD_W'((GRAIN_BYTES / 4) - 1);

  pmpCfgT            cfgQ  [REGION_COUNT];
  logic [WORD_W-1:0] addrQ [REGION_COUNT];
  logic [REGION_COUNT-1:0] matchVec;

  for (genvar g = 0; g < REGION_COUNT; g++) begin : g_region
    logic [WORD_W-1:0] napotMask;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgQ[g] <= '0;
      end else if (stb.cfgWe && stb.cfgWord == 4'(g / 4) && !cfgQ[g].lock) begin
        cfgQ[g] <= sanitizeCfg(csrWdata[8*(g%4) +: 8]);
      end
    end

    always_ff @(posedge clk) begin
      if (stb.addrWe && stb.addrIdx == 6'(g) && !cfgQ[g].lock) begin
        addrQ[g] <= csrWdata[WORD_W-1:0];
      end
    end

    always_comb begin
      napotMask   = (addrQ[g] ^ (addrQ[g] + 1'b1)) | GRAIN_MASK;
      matchVec[g] = (cfgQ[g].mode == MODE_NAPOT) &&
                    (((accAddr[ADDR_W-1:2] ^ addrQ[g]) & ~napotMask) == '0);
    end

    assign lockVec[g] = cfgQ[g].lock;
  end

  always_comb begin
    csrRdata = '0;
    for (int r = 0; r < REGION_COUNT; r++) begin
      if (stb.cfgRd && stb.cfgWord == 4'(r / 4))
        csrRdata[8*(r%4) +: 8] = cfgQ[r];
      if (stb.addrRd && stb.addrIdx == 6'(r))
        csrRdata = CSR_W'(addrQ[r]);
    end
  end

  logic found;
  logic allow;
  logic permOk;

  always_comb begin
    found  = 1'b0;
    allow  = accMachine;
    permOk = 1'b0;
    for (int r = 0; r < REGION_COUNT; r++) begin
      if (!found && matchVec[r]) begin
        found = 1'b1;
        unique case (accKindT'(accKind))
          ACC_STORE: permOk = cfgQ[r].w;
          ACC_FETCH: permOk = cfgQ[r].x;
          default:   permOk = cfgQ[r].r;
        endcase
        allow = (accMachine && !cfgQ[r].lock) || permOk;
      end
    end
    fault = accValid && !allow;
  end
endmodule

// File: rtl/pmp_unit.sv
module pmp_unit
  import pmp_pkg::*;
#(
  parameter int REGION_COUNT = 8,
  parameter int GRAIN_BYTES  = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csrWe,
  input  logic [11:0] csrAddr,
  input  logic [31:0] csrWdata,
  output logic [31:0] csrRdata,
  input  logic        accValid,
  input  logic [31:0] accAddr,
  input  logic [1:0]  accKind,
  input  logic        accMachine,
  output logic        fault
);
  csrStrobeT stb;
  logic [REGION_COUNT-1:0] lockVec;

  pmp_ctrl #(.REGION_COUNT(REGION_COUNT)) u_ctrl (
    .csrWe  (csrWe),
    .csrAddr(csrAddr),
    .stb    (stb)
  );

  pmp_datapath #(
    .REGION_COUNT(REGION_COUNT),
    .GRAIN_BYTES (GRAIN_BYTES),
    .ADDR_W      (32)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .csrWdata  (csrWdata),
    .csrRdata  (csrRdata),
    .accValid  (accValid),
    .accAddr   (accAddr),
    .accKind   (accKind),
    .accMachine(accMachine),
    .fault     (fault),
    .lockVec   (lockVec)
  );
endmodule

// File: rtl/pmp_unit_chk.sv
module pmp_unit_chk #(
  parameter int REGION_COUNT = 8
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [11:0]             csrAddr,
  input logic [31:0]             csrRdata,
  input logic                    accValid,
  input logic                    accMachine,
  input logic                    fault,
  input logic [REGION_COUNT-1:0] lockVec
);
  logic isCfg;
  logic isAddr;
  logic beyond;
  logic [11:0] addrOff;

  always_comb begin
    addrOff = csrAddr - 12'h3b0;
    isCfg   = csrAddr >= 12'h3a0 && csrAddr <= 12'h3af;
    isAddr  = csrAddr >= 12'h3b0 && csrAddr <= 12'h3ef;
    beyond  = (isCfg  && ({1'b0, csrAddr[3:0], 2'b00} >= 7'(REGION_COUNT))) ||
              (isAddr && ({1'b0, addrOff[5:0]} >= 7'(REGION_COUNT)));
  end

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    isCfg |-> (csrRdata & 32'h6060_6060) == 32'h0);

  // R3
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    isCfg |-> (csrRdata[4:3] != 2'b01 && csrRdata[4:3] != 2'b10 &&
               csrRdata[12:11] != 2'b01 && csrRdata[12:11] != 2'b10 &&
               csrRdata[20:19] != 2'b01 && csrRdata[20:19] != 2'b10 &&
               csrRdata[28:27] != 2'b01 && csrRdata[28:27] != 2'b10));

  // R4
  addr_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    isAddr |-> csrRdata[31:30] == 2'b00);

  // R5
  beyond_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    beyond |-> csrRdata == 32'h0);

  // R6
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (lockVec & $past(lockVec)) == $past(lockVec));

  // R9
  idle_no_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> !fault);

  // R10
  machine_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accMachine && lockVec == '0) |-> !fault);
endmodule

bind pmp_unit pmp_unit_chk #(.REGION_COUNT(REGION_COUNT)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .csrAddr   (csrAddr),
  .csrRdata  (csrRdata),
  .accValid  (accValid),
  .accMachine(accMachine),
  .fault     (fault),
  .lockVec   (u_dp.lockVec)
);

// File: tb/pmp_unit_test.sv
module pmp_unit_test;
  localparam int N     = 8;
  localparam int GRAIN = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csrWe = 1'b0;
  logic [11:0] csrAddr = 12'h0;
  logic [31:0] csrWdata = 32'h0;
  logic [31:0] csrRdata;
  logic        accValid = 1'b0;
  logic [31:0] accAddr = 32'h0;
  logic [1:0]  accKind = 2'd0;
  logic        accMachine = 1'b0;
  logic        fault;

  int checks = 0;
  int errors = 0;

  logic [7:0]  cfgM  [64];
  logic [29:0] addrM [64];

  always #10 clk = ~clk;

  pmp_unit #(.REGION_COUNT(N), .GRAIN_BYTES(GRAIN)) uut (.*);

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [7:0] cleanCfg(input logic [7:0] b);
    logic [1:0] m;
    m = (b[4:3] == 2'b11) ? 2'b11 : 2'b00;
    return {b[7], 2'b00, m, b[2:0]};
  endfunction

  function automatic logic [31:0] expRead(input logic [11:0] a);
    logic [31:0] v;
    v = 32'h0;
    if (a >= 12'h3a0 && a <= 12'h3af) begin
      for (int j = 0; j < 4; j++)
        if (int'(a[3:0]) * 4 + j < N) v[8*j +: 8] = cfgM[int'(a[3:0]) * 4 + j];
    end else if (a >= 12'h3b0 && a <= 12'h3ef) begin
      if (int'(a - 12'h3b0) < N) v = {2'b00, addrM[int'(a - 12'h3b0)]};
    end
    return v;
  endfunction

  function automatic logic expFault(input logic [31:0] ad, input logic [1:0] k,
                                    input logic m, input logic v);
    logic found, allow, perm;
    logic [29:0] mask;
    found = 1'b0;
    allow = m;
    for (int r = 0; r < N; r++) begin
      mask = (addrM[r] ^ (addrM[r] + 30'd1)) | 30'((GRAIN / 4) - 1);
      if (!found && cfgM[r][4:3] == 2'b11 && ((ad[31:2] ^ addrM[r]) & ~mask) == 30'h0) begin
        found = 1'b1;
        perm  = (k == 2'd1) ? cfgM[r][1] : (k == 2'd2) ? cfgM[r][2] : cfgM[r][0];
        allow = (m && !cfgM[r][7]) || perm;
      end
    end
    return v && !allow;
  endfunction

  task automatic csrWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csrAddr = a; csrWdata = d; csrWe = 1'b1;
    @(negedge clk);
    csrWe = 1'b0;
    if (a >= 12'h3a0 && a <= 12'h3af) begin
      for (int j = 0; j < 4; j++) begin
        int r = int'(a[3:0]) * 4 + j;
        if (r < N && !cfgM[r][7]) cfgM[r] = cleanCfg(d[8*j +: 8]);
      end
    end else if (a >= 12'h3b0 && a <= 12'h3ef) begin
      int i = int'(a - 12'h3b0);
      if (i < N && !cfgM[i][7]) addrM[i] = d[29:0];
    end
  endtask

  task automatic checkRead(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    csrAddr = a;
    #1;
    checks++;
    if (csrRdata !== e) begin
      errors++;
      $display("FAIL %s: csr %h actual=%h expected=%h", tag, a, csrRdata, e);
    end
  endtask

  task automatic checkAcc(input logic [31:0] ad, input logic [1:0] k, input logic m,
                          input logic v, input logic e, input string tag);
    @(negedge clk);
    accAddr = ad; accKind = k; accMachine = m; accValid = v;
    #1;
    checks++;
    if (fault !== e) begin
      errors++;
      $display("FAIL %s: addr %h kind %0d mach %0d actual=%b expected=%b",
               tag, ad, k, m, fault, e);
    end
    accValid = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    for (int r = 0; r < 64; r++) cfgM[r] = 8'h0;
    for (int r = 0; r < N; r++) csrWrite(12'h3b0 + 12'(r), 32'h0);
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd1234);
    for (int r = 0; r < 64; r++) begin cfgM[r] = 8'h0; addrM[r] = 30'h0; end
    doReset();

    // R1 reset state
    checkRead(12'h3a0, 32'h0, "R1");
    checkRead(12'h3a1, 32'h0, "R1");

    // R2 layout, reserved bits cleared
    csrWrite(12'h3a0, 32'hFF9F_1B07);
    checkRead(12'h3a0, 32'h9F9F_1B07, "R2");
    // R6 locked entries and address ignore writes
    csrWrite(12'h3a0, 32'h0);
    checkRead(12'h3a0, 32'h9F9F_0000, "R6");
    csrWrite(12'h3b2, 32'h123);
    checkRead(12'h3b2, 32'h0, "R6");
    doReset();
    checkRead(12'h3a0, 32'h0, "R6");

    // R3 unsupported modes fold to off
    csrWrite(12'h3a1, 32'h0000_1008);
    checkRead(12'h3a1, 32'h0, "R3");

    // R4 address width
    csrWrite(12'h3b1, 32'hFFFF_FFFF);
    checkRead(12'h3b1, 32'h3FFF_FFFF, "R4");

    // R5 unimplemented slots
    csrWrite(12'h3b8, 32'h0000_DEAD);
    checkRead(12'h3b8, 32'h0, "R5");
    csrWrite(12'h3a2, 32'hFFFF_FFFF);
    checkRead(12'h3a2, 32'h0, "R5");
    checkRead(12'h3ef, 32'h0, "R5");

    // R7 NAPOT 32-byte region at 0x1000, read only
    csrWrite(12'h3b0, 32'h403);
    csrWrite(12'h3a0, 32'h19);
    checkAcc(32'h1000, 2'd0, 1'b0, 1'b1, 1'b0, "R7");
    checkAcc(32'h101C, 2'd0, 1'b0, 1'b1, 1'b0, "R7");
    checkAcc(32'h1020, 2'd0, 1'b0, 1'b1, 1'b1, "R7");
    checkAcc(32'h0FFC, 2'd0, 1'b0, 1'b1, 1'b1, "R7");
    // R9 kinds
    checkAcc(32'h1004, 2'd1, 1'b0, 1'b1, 1'b1, "R9");
    checkAcc(32'h1004, 2'd2, 1'b0, 1'b1, 1'b1, "R9");
    checkAcc(32'h1004, 2'd3, 1'b0, 1'b1, 1'b0, "R9");
    checkAcc(32'h1004, 2'd1, 1'b0, 1'b0, 1'b0, "R9");

    // R8 overlap: region1 16 KiB rwx from 0
    csrWrite(12'h3b1, 32'h7FF);
    csrWrite(12'h3a0, 32'h1F19);
    checkAcc(32'h1004, 2'd1, 1'b0, 1'b1, 1'b1, "R8");
    checkAcc(32'h2000, 2'd1, 1'b0, 1'b1, 1'b0, "R8");

    // R10 privilege rules
    checkAcc(32'h1004, 2'd1, 1'b1, 1'b1, 1'b0, "R10");
    checkAcc(32'h8000, 2'd0, 1'b1, 1'b1, 1'b0, "R10");
    checkAcc(32'h8000, 2'd0, 1'b0, 1'b1, 1'b1, "R10");
    csrWrite(12'h3a0, 32'h1F99);
    checkAcc(32'h1004, 2'd1, 1'b1, 1'b1, 1'b1, "R10");
    checkAcc(32'h1004, 2'd0, 1'b1, 1'b1, 1'b0, "R10");

    // Random traffic against the model
    doReset();
    for (int it = 0; it < 1500; it++) begin
      int op;
      op = int'($urandom % 4);
      if (op == 0) begin
        logic [31:0] d;
        d = $urandom;
        if ($urandom % 8 != 0) d = d & 32'h7F7F_7F7F;
        csrWrite(12'h3a0 + 12'($urandom % 4), d);
      end else if (op == 1) begin
        int k;
        logic [29:0] v, lowMask;
        k = int'($urandom % 10);
        lowMask = (30'd1 << (k + 1)) - 30'd1;
        v = (30'($urandom) & 30'h3FFF & ~lowMask) | ((30'd1 << k) - 30'd1);
        csrWrite(12'h3b0 + 12'($urandom % 12), {2'b00, v});
      end else if (op == 2) begin
        logic [11:0] a;
        a = 12'h3a0 + 12'($urandom % 80);
        checkRead(a, expRead(a), "R2");
      end else begin
        logic [31:0] ad;
        logic [1:0] k;
        logic m, v;
        ad = {16'h0, 16'($urandom)};
        k = 2'($urandom);
        m = 1'($urandom);
        v = ($urandom % 8) != 0;
        checkAcc(ad, k, m, v, expFault(ad, k, m, v), "R8");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule